// File: doc/BRIEF.md
# Warp Memory Coalescer

This block takes one warp-wide memory instruction: a byte address for each of 32 lanes, every lane moving one 4-byte word, plus a mask of the lanes that take part. Lanes whose addresses fall in the same naturally aligned 128-byte segment are merged. The block then issues one transaction per distinct segment instead of one request per lane. Each transaction carries the segment base and a 32-bit mask of the lanes it serves.

Transactions leave one per cycle on a valid/ready handshake. They are ordered by the lowest-numbered lane that has not yet been served. The final transaction of an instruction is flagged, and the running transaction count is presented with every transaction. One cycle after completion, a done pulse shows the total count. A new instruction is taken only when the previous one has fully drained. An instruction with no active lanes finishes with no transactions at all.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, `req_ready_o` is 1, `txn_valid_o` is 0 and `done_o` is 0.
- R2: `txn_base_o` equals the lane address with bits [6:0] cleared, which is the 128-byte segment base.
- R3: All active lanes whose addresses share a segment are served by a single transaction. Bit i of `txn_lanes_o` stands for lane i, whose address sits at bits [32*i+31:32*i] of `req_addr_i`.
- R4: Lanes whose bit in `req_mask_i` is 0 appear in no transaction mask, and their addresses create no transactions.
- R5: Transactions are issued in order of the lowest-numbered active lane not yet served; a handshake clears every lane it covers.
- R6: While `txn_valid_o` is 1 and `txn_ready_i` is 0, the base, lane mask, last flag and count stay unchanged on the next cycle.
- R7: `req_ready_o` is 0 from the accepting clock edge until the last transaction's handshake, so no request is taken mid-drain.
- R8: `txn_last_o` is 1 only on the final transaction. While `txn_valid_o` is 1, `txn_count_o` gives the 1-based ordinal of the current transaction, so on the last transaction it equals the total.
- R9: `done_o` pulses for one cycle right after the last handshake. In that cycle `txn_count_o` holds the total, `txn_valid_o` is 0 and `req_ready_o` is 1.
- R10: A request with an all-zero mask issues no transaction. It gives a `done_o` pulse in the next cycle with `txn_count_o` equal to 0, even when accepted in the same cycle as a previous instruction's done pulse.
- R11: 32 active lanes reading consecutive words from an aligned base give exactly 1 transaction, and a lane stride of 128 bytes gives 32.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Coalescer idle, request can be taken |
| req_addr_i | input | 1024 | Per-lane byte addresses, lane i at bits 32*i+:32 |
| req_mask_i | input | 32 | Active lanes |
| txn_valid_o | output | 1 | Transaction available |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_base_o | output | 32 | 128-byte aligned segment base |
| txn_lanes_o | output | 32 | Lanes served by this transaction |
| txn_last_o | output | 1 | Final transaction of the instruction |
| txn_count_o | output | 6 | Ordinal of the current transaction, or the total while idle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in one cycle: the done pulse that closes one instruction, and the acceptance of the next request, which becomes possible because `req_ready_o` rises in that same cycle. The bench provokes this by holding a request with an all-zero mask on the input for the whole drain. The held request must stay unaccepted until the done cycle, and the drained transactions must be unaffected by it. The done pulse must show the old total, and the cycle after it must bring a second done pulse with a count of zero.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned LANES    = 32;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned SEG_BITS = 7;
endpackage

// File: rtl/coal_lane_pick.sv
// lowest set bit of the pending mask
module coal_lane_pick #(
  parameter int unsigned LANES = 32,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/coal_seg_match.sv
// lanes still pending whose segment equals the reference segment
module coal_seg_match #(
  parameter int unsigned LANES    = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEG_BITS = 7,
  localparam int unsigned TAG_W   = ADDR_W - SEG_BITS
) (
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        pend_i,
  input  logic [TAG_W-1:0]        ref_tag_i,
  output logic [LANES-1:0]        match_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAG_W-1:0] tag;
    assign tag        = addr_i[g*ADDR_W+SEG_BITS +: TAG_W];
    assign match_o[g] = pend_i[g] && (tag == ref_tag_i);
  end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned SB      = SEG_BITS,
  localparam int unsigned IDX_W  = $clog2(N_LANES),
  localparam int unsigned CNT_W  = $clog2(N_LANES + 1),
  localparam int unsigned TAG_W  = AW - SB
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [N_LANES*AW-1:0] req_addr_i,
  input  logic [N_LANES-1:0]    req_mask_i,
  output logic                  txn_valid_o,
  input  logic                  txn_ready_i,
  output logic [AW-1:0]         txn_base_o,
  output logic [N_LANES-1:0]    txn_lanes_o,
  output logic                  txn_last_o,
  output logic [CNT_W-1:0]      txn_count_o,
  output logic                  done_o
);

  logic [N_LANES*AW-1:0] addr_q;
  logic [N_LANES-1:0]    pend_q;
  logic                  busy_q;
  logic [CNT_W-1:0]      count_q;
  logic                  done_q;

  logic [IDX_W-1:0]      lead_idx;
  logic                  lead_any;
  logic [TAG_W-1:0]      lead_tag;
  logic [N_LANES-1:0]    match;
  logic [N_LANES-1:0]    pend_left;
  logic                  accept, fire, fire_last;

  coal_lane_pick #(.LANES(N_LANES)) u_pick (
    .pend_i (pend_q),
    .idx_o  (lead_idx),
    .any_o  (lead_any)
  );

  assign lead_tag = addr_q[lead_idx*AW+SB +: TAG_W];

  coal_seg_match #(.LANES(N_LANES), .ADDR_W(AW), .SEG_BITS(SB)) u_match (
    .addr_i    (addr_q),
    .pend_i    (pend_q),
    .ref_tag_i (lead_tag),
    .match_o   (match)
  );

  assign pend_left   = pend_q & ~match;
  assign req_ready_o = !busy_q;
  assign accept      = req_valid_i && req_ready_o;
  assign txn_valid_o = busy_q && lead_any;
  assign fire        = txn_valid_o && txn_ready_i;
  assign fire_last   = fire && (pend_left == '0);

  assign txn_base_o  = {lead_tag, {SB{1'b0}}};
  assign txn_lanes_o = match;
  assign txn_last_o  = txn_valid_o && (pend_left == '0);
  assign txn_count_o = txn_valid_o ? count_q + CNT_W'(1) : count_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr_i;
        pend_q  <= req_mask_i;
        count_q <= '0;
        busy_q  <= |req_mask_i;
        done_q  <= ~|req_mask_i;
      end else if (fire) begin
        pend_q  <= pend_left;
        count_q <= count_q + CNT_W'(1);
        if (fire_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_lanes_o)
      && $stable(txn_count_o) && $stable(txn_last_o)); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o); // R7
  AST_LANES_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_lanes_o != '0); // R3
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_ready_i && txn_last_o |=> !txn_valid_o && done_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(req_valid_i && req_ready_o) |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !txn_valid_o && req_ready_o); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_count_o <= CNT_W'(N_LANES)); // R8

endmodule

// File: tb/mem_coalescer_tb.sv
module mem_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, txn_ready = 0;
  logic [NL*32-1:0] req_addr = '0;
  logic [NL-1:0] req_mask = '0;
  logic req_ready, txn_valid, txn_last, done;
  logic [31:0] txn_base;
  logic [NL-1:0] txn_lanes;
  logic [5:0] txn_count;

  int checks = 0, failures = 0;
  bit finished = 0;
  int cyc = 0;

  logic [31:0] la [NL];
  logic [31:0] exp_base [NL];
  logic [NL-1:0] exp_lanes [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_coalescer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_mask_i(req_mask),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_base_o(txn_base), .txn_lanes_o(txn_lanes),
    .txn_last_o(txn_last), .txn_count_o(txn_count), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  // reference grouping: lowest unserved lane first, segment = addr & ~7F
  function automatic int build_exp(input logic [NL-1:0] m);
    logic [NL-1:0] left;
    int n;
    left = m;
    n = 0;
    while (left != '0) begin
      int lead;
      lead = 0;
      for (int i = NL - 1; i >= 0; i--) if (left[i]) lead = i;
      exp_base[n] = la[lead] & ~32'h7F;
      exp_lanes[n] = '0;
      for (int i = 0; i < NL; i++)
        if (left[i] && ((la[i] & ~32'h7F) == exp_base[n])) exp_lanes[n][i] = 1'b1;
      left &= ~exp_lanes[n];
      n++;
    end
    return n;
  endfunction

  task automatic run_instr(input logic [NL-1:0] m, input int rdy_pct, input bit overlap, input int want_n);
    int n, k, guard;
    n = build_exp(m);
    if (want_n >= 0) chk(n == want_n, "R11 model", 64'(n), 64'(want_n));
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_mask = m;
    for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = la[i];
    @(posedge clk);
    @(negedge clk);
    if (overlap) begin
      req_mask = '0;
      for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = $urandom;
    end else req_valid = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R10 empty done", 64'(done), 64'd1);
      chk(txn_count == 0, "R10 empty count", 64'(txn_count), 64'd0);
      chk(txn_valid == 1'b0, "R10 no txn", 64'(txn_valid), 64'd0);
      req_valid = 1'b0;
      return;
    end
    k = 0;
    guard = 0;
    while (k < n && guard < 400) begin
      txn_ready = (($urandom % 100) < rdy_pct);
      #1;
      chk(txn_valid == 1'b1, "R5 valid", 64'(txn_valid), 64'd1);
      chk(req_ready == 1'b0, "R7 busy", 64'(req_ready), 64'd0);
      chk(txn_base == exp_base[k], "R2 base", 64'(txn_base), 64'(exp_base[k]));
      chk(txn_lanes == exp_lanes[k], "R3 lanes", 64'(txn_lanes), 64'(exp_lanes[k]));
      chk(txn_last == (k == n - 1), "R8 last", 64'(txn_last), 64'(k == n - 1));
      chk(txn_count == 6'(k + 1), "R8 count", 64'(txn_count), 64'(k + 1));
      if (txn_ready) k++;
      @(posedge clk);
      @(negedge clk);
      guard++;
    end
    txn_ready = 1'b0;
    #1;
    chk(done == 1'b1, "R9 done", 64'(done), 64'd1);
    chk(txn_count == 6'(n), "R9 total", 64'(txn_count), 64'(n));
    chk(txn_valid == 1'b0, "R9 idle", 64'(txn_valid), 64'd0);
    chk(req_ready == 1'b1, "R9 ready", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    if (overlap) begin
      chk(done == 1'b1, "R10 overlap done", 64'(done), 64'd1);
      chk(txn_count == 0, "R10 overlap count", 64'(txn_count), 64'd0);
      req_valid = 1'b0;
    end else begin
      chk(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    #(CLK_PERIOD * 2);
    #1;
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(txn_valid == 1'b0, "R1 valid", 64'(txn_valid), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd1234));

    // R11 unit stride aligned
    for (int i = 0; i < NL; i++) la[i] = 32'h1000 + i * 4;
    run_instr('1, 100, 0, 1);
    // R11 stride 128
    for (int i = 0; i < NL; i++) la[i] = 32'h8000 + i * 128;
    run_instr('1, 100, 0, 32);
    // unaligned unit stride: two segments, with back-pressure (R6)
    for (int i = 0; i < NL; i++) la[i] = 32'h2040 + i * 4;
    run_instr('1, 30, 0, 2);
    // R5 reverse order segments
    for (int i = 0; i < NL; i++) la[i] = 32'h4000 + (NL - 1 - i) * 256 + (i % 3) * 4;
    run_instr('1, 60, 0, 32);
    // R4 inactive lanes far away must not appear
    for (int i = 0; i < NL; i++) la[i] = (i % 2 == 0) ? 32'h300 + i : 32'hF000_0000 + i * 512;
    run_instr(32'h5555_5555, 100, 0, 1);
    // R10 empty mask
    run_instr('0, 100, 0, 0);
    // broadcast, then overlap with an empty request
    for (int i = 0; i < NL; i++) la[i] = 32'h77;
    run_instr('1, 50, 1, 1);
    // random patterns
    for (int t = 0; t < 60; t++) begin
      int mode;
      mode = $urandom % 5;
      base = $urandom & ~32'h3;
      for (int i = 0; i < NL; i++) begin
        case (mode)
          0: la[i] = base + i * 4;
          1: la[i] = base + i * 8;
          2: la[i] = base + i * 128;
          3: la[i] = base + ($urandom % 1024);
          default: la[i] = $urandom & ~32'h3;
        endcase
      end
      run_instr((t % 4 == 0) ? '1 : 32'($urandom), 20 + ($urandom % 81), (t % 7 == 3), -1);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule